// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads two 32-bit entries from memory in sequence. The 10 most significant address bits select an entry in a page directory, whose base comes from a control-register input. That directory entry names a page table. The next 10 bits select an entry in that page table, which names a 4096-byte page frame. The low 12 bits pass through unchanged as the byte offset inside the frame.

A caller offers one request at a time on a valid/ready handshake. The walker issues its reads on a simple memory read port: it holds the enable and the address until the memory answers with a valid data word. The result stays on the response port until the caller accepts it. The result is either the physical address or a page fault. A fault also reports whether the directory entry or the table entry was the one found not present.

Top module: `page_walk_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0.
- R2: The first read of a walk goes to `{ctl_dir_base[31:12], 12'h000} + 4 * req_vaddr[31:22]`. Bits [11:0] of the base are ignored. The base is sampled when the request is accepted, so later changes to `ctl_dir_base` do not affect that walk.
- R3: Bit 0 of an entry is its present flag. A directory entry with bit 0 clear ends the walk after exactly one read, with `rsp_fault`=1, `rsp_fault_tbl`=0 and `rsp_paddr`=0.
- R4: When the directory entry is present, the second read goes to `{pde[31:12], 12'h000} + 4 * req_vaddr[21:12]`, and the walk makes exactly two reads.
- R5: A table entry with bit 0 clear gives `rsp_fault`=1, `rsp_fault_tbl`=1 and `rsp_paddr`=0.
- R6: A present table entry gives `rsp_fault`=0, `rsp_fault_tbl`=0 and `rsp_paddr` = `{pte[31:12], req_vaddr[11:0]}`.
- R7: Only one request is handled at a time. `req_ready` is 0 from acceptance until the response has been taken, and a request offered while a response is pending is not accepted in that cycle.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields are held steady. A cycle with both signals at 1 ends the response, and `req_ready` returns to 1 in the next cycle.
- R9: While a read is outstanding, `mem_rd_en` stays at 1 and `mem_rd_addr` stays unchanged until `mem_rd_valid` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker is idle and takes the request |
| req_vaddr | input | 32 | Linear address to translate |
| ctl_dir_base | input | 32 | Control register; bits [31:12] give the directory frame |
| mem_rd_en | output | 1 | Read outstanding |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Read data returned this cycle |
| mem_rd_data | input | 32 | Entry word returned by memory |
| rsp_valid | output | 1 | Translation result available |
| rsp_ready | input | 1 | Caller takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 1 | Page fault: an entry was not present |
| rsp_fault_tbl | output | 1 | The fault came from the table entry, not the directory entry |

## Verification
Two of the block's functions can meet in one cycle: handing back a result and taking a new request. The bench chains transactions. On the same falling edge where it raises `rsp_ready` for a result, it also raises `req_valid` for the next address. It then checks that the response has ended, that no read was started, and that `req_ready` has returned, all before the pending request can be taken on the following edge. The bench also keeps `rsp_ready` low for a varying number of cycles to test that the response holds, and it corrupts the base and address inputs right after acceptance to show that the walk uses only the sampled values.

// File: rtl/pw_pkg.sv
`timescale 1ns/1ps
package pw_pkg;
  localparam int PW_ADDR_W        = 32;
  localparam int PW_DIR_W         = 10;
  localparam int PW_TBL_W         = 10;
  localparam int PW_OFS_W         = 12;
  localparam int PW_ENTRY_W       = 32;
  localparam int PW_PRESENT_BIT   = 0;
  localparam int PW_ENTRY_BYTES_LG = 2;
  localparam int PW_FRAME_W       = PW_ADDR_W - PW_OFS_W;

  typedef enum logic [1:0] {WS_IDLE, WS_DIR, WS_TBL, WS_DONE} walk_state_e;
  typedef logic [PW_FRAME_W-1:0] frame_t;
  typedef logic [PW_ADDR_W-1:0]  addr_t;

  function automatic addr_t dir_index(input addr_t va);
    return addr_t'(va[PW_ADDR_W-1 -: PW_DIR_W]);
  endfunction

  function automatic addr_t tbl_index(input addr_t va);
    return addr_t'(va[PW_OFS_W +: PW_TBL_W]);
  endfunction

  function automatic addr_t entry_addr(input frame_t base, input addr_t idx);
    return {base, {PW_OFS_W{1'b0}}} + (idx << PW_ENTRY_BYTES_LG);
  endfunction

  function automatic frame_t entry_frame(input logic [PW_ENTRY_W-1:0] e);
    return e[PW_ENTRY_W-1 -: PW_FRAME_W];
  endfunction

  function automatic logic entry_present(input logic [PW_ENTRY_W-1:0] e);
    return e[PW_PRESENT_BIT];
  endfunction

  function automatic addr_t join_phys(input frame_t f, input logic [PW_OFS_W-1:0] ofs);
    return {f, ofs};
  endfunction
endpackage

// File: rtl/pw_walk_regs.sv
`timescale 1ns/1ps
module pw_walk_regs
  import pw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   accept,
  input  addr_t  vaddr_in,
  input  frame_t base_in,
  input  logic   pde_load,
  input  frame_t pde_in,
  output addr_t  va_q,
  output frame_t base_q,
  output frame_t pde_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q   <= '0;
      base_q <= '0;
      pde_q  <= '0;
    end else begin
      if (accept) begin
        va_q   <= vaddr_in;
        base_q <= base_in;
      end
      if (pde_load) pde_q <= pde_in;
    end
  end
endmodule

// File: rtl/pw_fsm.sv
`timescale 1ns/1ps
module pw_fsm
  import pw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_rd_valid,
  input  logic rd_present,
  input  logic rsp_ready,
  output logic req_ready,
  output logic mem_rd_en,
  output logic rd_sel_tbl,
  output logic accept,
  output logic pde_load,
  output logic dir_fault_evt,
  output logic walk_done_evt,
  output logic rsp_valid
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d       = state_q;
    req_ready     = 1'b0;
    mem_rd_en     = 1'b0;
    rd_sel_tbl    = 1'b0;
    pde_load      = 1'b0;
    dir_fault_evt = 1'b0;
    walk_done_evt = 1'b0;
    rsp_valid     = 1'b0;
    unique case (state_q)
      WS_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) state_d = WS_DIR;
      end
      WS_DIR: begin
        mem_rd_en = 1'b1;
        if (mem_rd_valid) begin
          if (rd_present) begin
            pde_load = 1'b1;
            state_d  = WS_TBL;
          end else begin
            dir_fault_evt = 1'b1;
            state_d       = WS_DONE;
          end
        end
      end
      WS_TBL: begin
        mem_rd_en  = 1'b1;
        rd_sel_tbl = 1'b1;
        if (mem_rd_valid) begin
          walk_done_evt = 1'b1;
          state_d       = WS_DONE;
        end
      end
      WS_DONE: begin
        rsp_valid = 1'b1;
        if (rsp_ready) state_d = WS_IDLE;
      end
      default: state_d = WS_IDLE;
    endcase
  end

  assign accept = req_ready & req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= WS_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/pw_rsp_reg.sv
`timescale 1ns/1ps
module pw_rsp_reg
  import pw_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dir_fault_evt,
  input  logic                walk_done_evt,
  input  logic                rd_present,
  input  frame_t              rd_frame,
  input  logic [PW_OFS_W-1:0] ofs,
  output addr_t               paddr_q,
  output logic                fault_q,
  output logic                fault_tbl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      paddr_q     <= '0;
      fault_q     <= 1'b0;
      fault_tbl_q <= 1'b0;
    end else if (dir_fault_evt) begin
      paddr_q     <= '0;
      fault_q     <= 1'b1;
      fault_tbl_q <= 1'b0;
    end else if (walk_done_evt) begin
      paddr_q     <= rd_present ? join_phys(rd_frame, ofs) : '0;
      fault_q     <= ~rd_present;
      fault_tbl_q <= ~rd_present;
    end
  end
endmodule

// File: rtl/page_walk_unit.sv
`timescale 1ns/1ps
module page_walk_unit
  import pw_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [PW_ADDR_W-1:0]  req_vaddr,
  input  logic [PW_ADDR_W-1:0]  ctl_dir_base,
  output logic                  mem_rd_en,
  output logic [PW_ADDR_W-1:0]  mem_rd_addr,
  input  logic                  mem_rd_valid,
  input  logic [PW_ENTRY_W-1:0] mem_rd_data,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [PW_ADDR_W-1:0]  rsp_paddr,
  output logic                  rsp_fault,
  output logic                  rsp_fault_tbl
);
  logic   accept, pde_load, rd_sel_tbl, rd_present;
  logic   dir_fault_evt, walk_done_evt;
  addr_t  va_q;
  frame_t base_q, pde_q, rd_frame;
  logic   unused_bits;

  assign rd_present  = entry_present(mem_rd_data);
  assign rd_frame    = entry_frame(mem_rd_data);
  assign unused_bits = ^{ctl_dir_base[PW_OFS_W-1:0], mem_rd_data[PW_OFS_W-1:PW_PRESENT_BIT+1]};

  pw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mem_rd_valid(mem_rd_valid),
    .rd_present(rd_present), .rsp_ready(rsp_ready), .req_ready(req_ready),
    .mem_rd_en(mem_rd_en), .rd_sel_tbl(rd_sel_tbl), .accept(accept),
    .pde_load(pde_load), .dir_fault_evt(dir_fault_evt),
    .walk_done_evt(walk_done_evt), .rsp_valid(rsp_valid)
  );

  pw_walk_regs u_regs (
    .clk(clk), .rst_n(rst_n), .accept(accept), .vaddr_in(req_vaddr),
    .base_in(ctl_dir_base[PW_ADDR_W-1:PW_OFS_W]), .pde_load(pde_load),
    .pde_in(rd_frame), .va_q(va_q), .base_q(base_q), .pde_q(pde_q)
  );

  assign mem_rd_addr = rd_sel_tbl ? entry_addr(pde_q, tbl_index(va_q))
                                  : entry_addr(base_q, dir_index(va_q));

  pw_rsp_reg u_rsp (
    .clk(clk), .rst_n(rst_n), .dir_fault_evt(dir_fault_evt),
    .walk_done_evt(walk_done_evt), .rd_present(rd_present), .rd_frame(rd_frame),
    .ofs(va_q[PW_OFS_W-1:0]), .paddr_q(rsp_paddr), .fault_q(rsp_fault),
    .fault_tbl_q(rsp_fault_tbl)
  );
endmodule

// File: rtl/pw_checker.sv
`timescale 1ns/1ps
module pw_checker
  import pw_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_ready,
  input logic                 mem_rd_en,
  input logic [PW_ADDR_W-1:0] mem_rd_addr,
  input logic                 mem_rd_valid,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [PW_ADDR_W-1:0] rsp_paddr,
  input logic                 rsp_fault,
  input logic                 rsp_fault_tbl,
  input logic                 dir_fault_evt
);
  AST_DIR_FAULT_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dir_fault_evt |=> (!mem_rd_en && rsp_valid && rsp_fault && !rsp_fault_tbl)); // R3
  AST_FAULT_ZERO_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R5
  AST_SINGLE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_rd_en) |-> !req_ready); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_fault_tbl))); // R8
  AST_RSP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (!rsp_valid && req_ready)); // R8
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_rd_addr))); // R9
endmodule

bind page_walk_unit pw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_rd_en(mem_rd_en),
  .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
  .rsp_fault_tbl(rsp_fault_tbl), .dir_fault_evt(dir_fault_evt)
);

// File: tb/page_walk_unit_tb_top.sv
`timescale 1ns/1ps
module page_walk_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_vaddr = '0, ctl_dir_base = '0;
  logic        mem_rd_en, mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_addr, mem_rd_data = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_fault, rsp_fault_tbl;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int mem_lat = 0, mem_cnt = 0, nrd = 0;
  bit mem_busy = 0;
  logic [31:0] mem_cap = '0;
  logic [31:0] rd_log [0:3];

  always #4 clk = ~clk;

  page_walk_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .ctl_dir_base(ctl_dir_base), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_fault_tbl(rsp_fault_tbl)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic p;
    p = ~(a[2] ^ a[7] ^ a[13]);
    return {a[21:2] ^ 20'hA5A5A, 11'h000, p};
  endfunction

  function automatic logic [31:0] va_of(input int k);
    return {10'(k * 7 + 3), 10'(k * 13 + 1), 12'(k * 291)};
  endfunction

  function automatic logic [31:0] base_of(input int k);
    return {20'(k * 4951 + 17), 12'(k * 37)};
  endfunction

  task automatic show_summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      show_summary();
      $finish;
    end
  end

  // memory model: works on falling edges, answers after mem_lat extra falling edges
  always @(negedge clk) begin
    if (mem_rd_valid) begin
      mem_rd_valid = 1'b0;
      mem_busy = 0;
    end
    if (!mem_busy && mem_rd_en) begin
      mem_busy = 1;
      mem_cnt = mem_lat;
      mem_cap = mem_rd_addr;
      if (nrd < 4) rd_log[nrd] = mem_rd_addr;
      nrd++;
    end
    if (mem_busy && !mem_rd_valid) begin
      if (mem_cnt == 0) begin
        mem_rd_valid = 1'b1;
        mem_rd_data = mem_word(mem_cap);
      end else mem_cnt--;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_txn(input logic [31:0] va, input logic [31:0] base, input int hold,
                        input logic [31:0] nva, input logic [31:0] nbase, input bit last);
    logic [31:0] pde_a, pde, pte_a, pte, exp_pa, pa0;
    bit exp_f, exp_ft, f0, ft0, ready_bad, hold_bad;
    int exp_n;
    pde_a = {base[31:12], 12'h000} + {20'h0, va[31:22], 2'b00};
    pde = mem_word(pde_a);
    pte_a = {pde[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    pte = mem_word(pte_a);
    if (!pde[0]) begin
      exp_n = 1; exp_f = 1; exp_ft = 0; exp_pa = 0;
    end else begin
      exp_n = 2; exp_f = !pte[0]; exp_ft = !pte[0];
      exp_pa = pte[0] ? {pte[31:12], va[11:0]} : 32'h0;
    end
    req_valid = 1'b1; req_vaddr = va; ctl_dir_base = base; nrd = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = ~va; ctl_dir_base = ~base;
    ready_bad = 0;
    while (!rsp_valid) begin
      if (req_ready) ready_bad = 1;
      @(negedge clk);
    end
    if (req_ready) ready_bad = 1;
    pa0 = rsp_paddr; f0 = rsp_fault; ft0 = rsp_fault_tbl; hold_bad = 0;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      if (rsp_valid !== 1'b1 || rsp_paddr !== pa0 || rsp_fault !== f0 || rsp_fault_tbl !== ft0) hold_bad = 1;
      if (req_ready) ready_bad = 1;
    end
    chk(rd_log[0] == pde_a, "R2 directory entry address", rd_log[0], pde_a);
    chk(nrd == exp_n, exp_n == 1 ? "R3 single read on absent directory entry" : "R4 two reads", nrd, exp_n);
    if (exp_n == 2) chk(rd_log[1] == pte_a, "R4 table entry address", rd_log[1], pte_a);
    chk(rsp_fault == exp_f && rsp_fault_tbl == exp_ft, exp_ft ? "R5 table fault flags" : (exp_f ? "R3 directory fault flags" : "R6 no fault"),
        {rsp_fault, rsp_fault_tbl}, {exp_f, exp_ft});
    chk(rsp_paddr == exp_pa, exp_f ? "R5 fault paddr zero" : "R6 physical address", rsp_paddr, exp_pa);
    chk(!ready_bad, "R7 req_ready low while busy", ready_bad, 0);
    chk(!hold_bad, "R8 response held under backpressure", hold_bad, 0);
    rsp_ready = 1'b1;
    if (!last) begin
      req_valid = 1'b1; req_vaddr = nva; ctl_dir_base = nbase;
    end
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && !mem_rd_en && req_ready, "R7 R8 response ends, pending request not taken during handshake",
        {rsp_valid, mem_rd_en, req_ready}, 3'b001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_rd_en === 1'b0, "R1 reset state",
        {req_ready, rsp_valid, mem_rd_en}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 120; k++) begin
      mem_lat = k / 40;
      do_txn(va_of(k), base_of(k), k % 4, va_of(k + 1), base_of(k + 1), k == 119);
    end
    show_summary();
    $finish;
  end
endmodule